// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block is a small bit-addressed register. A binary address chooses one of its storage bits, and a single data line supplies the value for that bit. All bits are presented in parallel on the output bus at all times. Two control inputs select one of four operating modes: keep, addressed write, clear everything, or 1-of-N demultiplexer. The control inputs are a write inhibit (`wr_dis_i`) and a functional clear (`clr_i`).

Storage is clocked on the rising edge. The output path is combinational, so a bit that is open to the data input shows that input within the same cycle. The value on the output at a clock edge becomes the stored value for later cycles. In demultiplexer mode the unaddressed bits are cleared in storage, not just masked at the output.

A separate active-low asynchronous reset (`rst_n`) puts the storage in a known all-zero state.

Top module: `addr_latch`

## Requirements
- R1: In addressed-write mode (`wr_dis_i`=0, `clr_i`=0), only the bit whose index equals `addr_i` can take a new stored value at a rising edge.
- R2: In keep mode (`wr_dis_i`=1, `clr_i`=0), no stored bit changes at a rising edge.
- R3: In keep mode, `q_o` equals the stored contents, whatever `addr_i` and `din_i` are.
- R4: In clear mode (`wr_dis_i`=1, `clr_i`=1), `q_o` is all zeros within the same cycle, and storage is all zeros after the next rising edge.
- R5: In demultiplexer mode (`wr_dis_i`=0, `clr_i`=1), `q_o[addr_i]` equals `din_i` and every other bit of `q_o` is 0.
- R6: In addressed-write mode, `q_o[addr_i]` equals `din_i` within the same cycle, and every other bit shows its stored value.
- R7: At every rising edge with `rst_n` high, the stored contents become the value `q_o` had just before that edge.
- R8: After demultiplexer mode is left for keep mode, the unaddressed bits read 0. The bit addressed at the final demultiplexer edge reads the `din_i` sampled at that edge.
- R9: When the address moves during addressed-write mode, the previously addressed bit keeps the value it held at the last edge at which it was addressed.
- R10: While `rst_n` is low, storage is all zeros, so `q_o` reads 0 in keep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the storage |
| rst_n | input | 1 | Asynchronous active-low reset of the storage |
| addr_i | input | ADDR_W (3) | Index of the target bit |
| din_i | input | 1 | Data value for the target bit |
| wr_dis_i | input | 1 | Write inhibit: 1 blocks the addressed write |
| clr_i | input | 1 | Functional clear, used with `wr_dis_i` to pick the mode |
| q_o | output | NBITS (8) | Parallel view of all bits |

## Verification
The hardest state to reach is one where the two control inputs change mode between consecutive edges while the address moves. Such a sequence is the only way to show that demultiplexer mode really clears storage and that a bit left behind by an address change keeps its last captured value. The bench sweeps every mode against every address and both data values, each step from whatever the previous step left behind. It then runs long random sequences of mode, address and data. It also runs directed demultiplexer-to-keep and address-walk sequences. A bench-side reference model predicts each cycle's output before the edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    LM_HOLD  = 2'd0,
    LM_WRITE = 2'd1,
    LM_CLEAR = 2'd2,
    LM_DEMUX = 2'd3
  } lmode_e;

  // Map the two control pins onto an operating mode.
  function automatic lmode_e lm_decode(input logic wr_dis, input logic clr);
    lmode_e m;
    case ({clr, wr_dis})
      2'b00:   m = LM_WRITE;
      2'b01:   m = LM_HOLD;
      2'b11:   m = LM_CLEAR;
      default: m = LM_DEMUX;
    endcase
    return m;
  endfunction

  // Next value of one storage bit; also what the bit shows this cycle.
  function automatic logic lm_next_bit(input lmode_e m, input logic sel,
                                       input logic din, input logic cur);
    logic v;
    case (m)
      LM_HOLD:  v = cur;
      LM_WRITE: v = sel ? din : cur;
      LM_CLEAR: v = 1'b0;
      LM_DEMUX: v = sel ? din : 1'b0;
      default:  v = cur;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/latch_mode_dec.sv
module latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic   wr_dis_i,
  input  logic   clr_i,
  output lmode_e mode_o,
  output logic   write_en_o,
  output logic   clear_all_o,
  output logic   demux_on_o
);

  lmode_e mode_w;

  assign mode_w      = lm_decode(wr_dis_i, clr_i);
  assign mode_o      = mode_w;
  assign write_en_o  = (mode_w == LM_WRITE);
  assign clear_all_o = (mode_w == LM_CLEAR);
  assign demux_on_o  = (mode_w == LM_DEMUX);

endmodule

// File: rtl/latch_addr_dec.sv
module latch_addr_dec #(
  parameter int NBITS  = 8,
  parameter int ADDR_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NBITS-1:0]  sel_o
);

  for (genvar g = 0; g < NBITS; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(g));
  end

endmodule

// File: rtl/latch_bit_slice.sv
module latch_bit_slice
  import addr_latch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lmode_e mode_i,
  input  logic   sel_i,
  input  logic   din_i,
  output logic   view_o,
  output logic   store_o
);

  logic store_q;
  logic nxt_w;

  assign nxt_w = lm_next_bit(mode_i, sel_i, din_i, store_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= 1'b0;
    else        store_q <= nxt_w;
  end

  assign view_o  = nxt_w;
  assign store_o = store_q;

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int NBITS  = 8,
  parameter int ADDR_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  input  logic              wr_dis_i,
  input  logic              clr_i,
  output logic [NBITS-1:0]  q_o
);

  lmode_e            mode;
  logic              write_en;
  logic              clear_all;
  logic              demux_on;
  logic [NBITS-1:0]  sel_vec;
  logic [NBITS-1:0]  store_q;

  latch_mode_dec u_mode (
    .wr_dis_i    (wr_dis_i),
    .clr_i       (clr_i),
    .mode_o      (mode),
    .write_en_o  (write_en),
    .clear_all_o (clear_all),
    .demux_on_o  (demux_on)
  );

  latch_addr_dec #(.NBITS(NBITS), .ADDR_W(ADDR_W)) u_addr (
    .addr_i (addr_i),
    .sel_o  (sel_vec)
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    latch_bit_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode),
      .sel_i   (sel_vec[b]),
      .din_i   (din_i),
      .view_o  (q_o[b]),
      .store_o (store_q[b])
    );
  end

endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int NBITS  = 8,
  parameter int ADDR_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              din_i,
  input logic              write_en,
  input logic              clear_all,
  input logic              demux_on,
  input logic [NBITS-1:0]  sel_vec,
  input logic [NBITS-1:0]  store_q,
  input logic [NBITS-1:0]  q_o
);

  AST_WRITE_ONLY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(write_en) |-> (((store_q ^ $past(store_q)) & ~$past(sel_vec)) == '0)); // R1

  AST_HOLD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(write_en) && !$past(clear_all) && !$past(demux_on)
      |-> store_q == $past(store_q)); // R2

  AST_HOLD_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    !write_en && !clear_all && !demux_on |-> q_o == store_q); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |-> q_o == '0); // R4

  AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    demux_on |-> $onehot0(q_o) && (q_o[addr_i] == din_i)); // R5

  AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    write_en |-> ((q_o & ~sel_vec) == (store_q & ~sel_vec)) && (q_o[addr_i] == din_i)); // R6

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> store_q == $past(q_o)); // R7

endmodule

bind addr_latch addr_latch_chk #(.NBITS(NBITS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .din_i     (din_i),
  .write_en  (write_en),
  .clear_all (clear_all),
  .demux_on  (demux_on),
  .sel_vec   (sel_vec),
  .store_q   (store_q),
  .q_o       (q_o)
);

// File: tb/tb_addr_latch.sv
`timescale 1ns/1ps
module tb_addr_latch;

  localparam int NB = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic          wd = 1'b1;
  logic          cl = 1'b0;
  logic [NB-1:0] q;

  logic [NB-1:0] model = '0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_latch #(.NBITS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din),
    .wr_dis_i(wd), .clr_i(cl), .q_o(q)
  );

  // Expected view: clear pins both high -> zero; enabled target -> data;
  // clear alone -> zero; otherwise the remembered bit.
  function automatic logic [NB-1:0] expect_view(input logic [NB-1:0] mem,
      input int a, input logic d, input logic w, input logic c);
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) begin
      if (c && w)             r[i] = 1'b0;
      else if (i == a && !w)  r[i] = d;
      else if (c)             r[i] = 1'b0;
      else                    r[i] = mem[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b (addr=%0d din=%b wd=%b cl=%b)",
               req, act, exp, addr, din, wd, cl);
    end
  endtask

  // Drive one cycle: inputs after the falling edge, check the view, then
  // the model takes the expected view at the rising edge (R7).
  task automatic step(input int a, input logic d, input logic w, input logic c, input string req);
    logic [NB-1:0] e;
    @(negedge clk);
    addr = AW'(a); din = d; wd = w; cl = c;
    #1;
    e = expect_view(model, a, d, w, c);
    check(req, q, e);
    @(posedge clk);
    model = e;
  endtask

  function automatic string mode_tag(input logic w, input logic c);
    if (!w && !c) return "R6";
    if (w && !c)  return "R3";
    if (w && c)   return "R4";
    return "R5";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // Reset state R10
    repeat (2) @(negedge clk);
    #1 check("R10", q, '0);
    addr = 3'd5;
    #1 check("R10", q, '0);
    @(negedge clk) rst_n = 1'b1;

    // R6 / R7: write a pattern bit by bit, then confirm it in keep mode
    for (int a = 0; a < NB; a++) step(a, logic'(a % 3 == 0), 1'b0, 1'b0, "R6");
    for (int a = 0; a < NB; a++) step(a, ~din, 1'b1, 1'b0, "R3");
    check("R7", model, 8'b0100_1001);

    // R2 / R3: address and data wander under the inhibit
    for (int a = NB - 1; a >= 0; a--) step(a, logic'(a[0]), 1'b1, 1'b0, "R2");

    // R9: move the address while writing
    step(2, 1'b1, 1'b0, 1'b0, "R9");
    step(4, 1'b1, 1'b0, 1'b0, "R9");
    step(2, 1'b0, 1'b1, 1'b0, "R9");
    check("R9", {7'b0, q[2]}, 8'd1);

    // R5 then leave into keep mode: R8
    step(0, 1'b1, 1'b1, 1'b0, "R3");
    step(6, 1'b0, 1'b0, 1'b1, "R5");
    step(3, 1'b1, 1'b0, 1'b1, "R5");
    step(7, 1'b1, 1'b1, 1'b0, "R8");
    check("R8", q, 8'b0000_1000);

    // R4: clear everything
    for (int a = 0; a < NB; a++) step(a, 1'b1, 1'b0, 1'b0, "R1");
    step(1, 1'b1, 1'b1, 1'b1, "R4");
    step(1, 1'b0, 1'b1, 1'b0, "R4");
    check("R4", q, '0);

    // Exhaustive sweep over mode x address x data, R1 across each step
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < NB; a++)
        for (int d = 0; d < 2; d++) begin
          step(a, logic'(d), logic'(m[0]), logic'(m[1]), mode_tag(logic'(m[0]), logic'(m[1])));
          step((a + 3) % NB, logic'(d ^ 1), 1'b1, 1'b0, "R1");
        end

    // Random run
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic w, c;
      r = $urandom;
      w = r[0]; c = r[1] & r[2];
      step(r[10:8], r[4], w, c, mode_tag(w, c));
    end

    // R10 again mid-run
    for (int a = 0; a < NB; a++) step(a, 1'b1, 1'b0, 1'b0, "R6");
    @(negedge clk);
    wd = 1'b1; cl = 1'b0; rst_n = 1'b0;
    #1 check("R10", q, '0);
    model = '0;
    @(negedge clk) rst_n = 1'b1;
    step(4, 1'b1, 1'b1, 1'b0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule